// File: doc/BRIEF.md
# Trimmable One-Shot Clock Regulator

The block divides a reference clock, nominally 32,768 Hz, by 128 to produce a regulated 256 Hz clock. Each output period is a low phase followed by a high phase of 64 reference ticks each. Slow drift of the reference can be corrected by software. Software loads a 6-bit trim code and issues a single-cycle trigger, and the block then stretches or shrinks exactly one output period by a signed number of reference ticks.

The correction is decoded as n = (code read as two's complement) + 1. Codes 0x00 to 0x1F therefore give +1 to +32 ticks, codes 0x20 to 0x3E give -31 to -1 ticks, and 0x3F gives no change. A positive n lengthens the period, so the clock runs slower. A negative n shortens it, so the clock runs faster. Each trigger corrects one period only, so periodic regulation needs a fresh trigger each time, for example from a timer every ten seconds. The adjustment goes into the low phase. The high phase always stays 64 ticks, so the corrected low phase lasts 33 to 96 ticks.

Top module: `tick_trim_divider`

## Requirements
- R1: While reset is asserted, `reg_clk` and `busy` are 0. After reset is released, the first low phase lasts 64 reference ticks.
- R2: With no correction active, every low phase and every high phase lasts 64 ticks, giving a period of 128 ticks.
- R3: The trim code is decoded as n = signed(code) + 1. For example, 0x00 gives +1, 0x1F gives +32, 0x20 gives -31, 0x3E gives -1 and 0x3F gives 0.
- R4: In the corrected period, the low phase lasts 64 + n ticks and the high phase lasts 64 ticks.
- R5: A trigger is sampled on a clock edge. The correction applies to the first period whose low phase begins on a later edge than that sample.
- R6: Each accepted trigger corrects exactly one period. The period that follows it is back to 64 + 64 ticks.
- R7: `busy` is 1 from the edge that samples an accepted trigger until the edge that ends the corrected period's high phase. At that edge it goes to 0.
- R8: A trigger that arrives while `busy` is 1 is ignored. The correction amount and the timing of the pending correction are unchanged.
- R9: Code 0x3F still raises `busy` for one corrected period, but that period stays at 128 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (nominally 32,768 Hz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| trim_code | input | 6 | Trim code, sampled when a trigger is accepted |
| trim_go | input | 1 | Single-cycle regulation trigger |
| reg_clk | output | 1 | Regulated clock; each period is low then high |
| busy | output | 1 | A correction is pending or in progress |

## Verification
The bench covers the extreme codes 0x1F and 0x20, the zero code 0x3F, and the codes next to the sign boundary. A wrong decoder would be off by one or would flip the sign at the 0x1F/0x20 boundary, and the measured low phase would then miss 64 + n.

Triggers arrive at random offsets in the period, including the last high cycle. A design that corrected the period already running, or that applied the correction twice, would show a wrong low-phase length in the period being measured or in the one after it.

A second trigger carrying a different code is issued while the first correction is still pending. A design that re-latched the code or restarted the sequence would show the second correction amount, or would hold `busy` too long.

// File: rtl/tick_trim_divider.sv
module tick_trim_divider #(
  parameter int HALF   = 64,
  parameter int TRIM_W = 6
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [TRIM_W-1:0] trim_code,
  input  logic              trim_go,
  output logic              reg_clk,
  output logic              busy
);
  localparam int CW = $clog2(2*HALF);

  logic [CW-1:0]        cnt;
  logic                 hi, pend, act;
  logic [TRIM_W-1:0]    code_q;
  logic signed [TRIM_W:0] adj;
  logic [CW-1:0]        low_len;
  logic                 hi_end, lo_end, accept;

  assign adj     = $signed({code_q[TRIM_W-1], code_q}) + $signed((TRIM_W+1)'(1));
  assign low_len = act ? CW'(HALF + int'(adj)) : CW'(HALF);
  assign hi_end  = hi && (cnt == CW'(HALF-1));
  assign lo_end  = !hi && (cnt == low_len - CW'(1));
  assign accept  = trim_go && !pend && !act;
  assign reg_clk = hi;
  assign busy    = pend | act;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      hi     <= 1'b0;
      pend   <= 1'b0;
      act    <= 1'b0;
      code_q <= '1;
    end else begin
      if (hi_end || lo_end) begin
        cnt <= '0;
        hi  <= !hi;
      end else begin
        cnt <= cnt + CW'(1);
      end
      if (hi_end) begin
        act  <= pend;
        pend <= 1'b0;
      end
      if (accept) begin
        pend   <= 1'b1;
        code_q <= trim_code;
      end
    end
  end

  AST_HIGH_LEN: assert property (@(posedge ref_clk) disable iff (!rst_n) hi |-> cnt < CW'(HALF)); // R4
  AST_LOW_LEN: assert property (@(posedge ref_clk) disable iff (!rst_n) (!hi && !act) |-> cnt < CW'(HALF)); // R2
  AST_ONE_SHOT: assert property (@(posedge ref_clk) disable iff (!rst_n) (hi_end && act) |=> !busy); // R6
  AST_IGNORE_BUSY: assert property (@(posedge ref_clk) disable iff (!rst_n) (trim_go && busy) |=> $stable(code_q)); // R8
  AST_BUSY_RISE: assert property (@(posedge ref_clk) disable iff (!rst_n) (trim_go && !busy) |=> busy); // R7
  AST_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n) !(pend && act)); // R5
endmodule

// File: tb/sim_tick_trim_divider.sv
module sim_tick_trim_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] trim_code = '0;
  logic       trim_go = 1'b0;
  logic       reg_clk, busy;
  int         npass = 0, ntot = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  tick_trim_divider u0 (.ref_clk(clk), .rst_n(rst_n), .trim_code(trim_code),
                        .trim_go(trim_go), .reg_clk(reg_clk), .busy(busy));

  function automatic int expn(input logic [5:0] c);
    return (c < 6'd32) ? int'(c) + 1 : int'(c) - 63;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntot++;
    if (ok) npass++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic count_phase(input logic lvl, output int n);
    n = 0;
    while (reg_clk == lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic trial(input logic [5:0] code, input int dly, input bit second, input logic [5:0] code2);
    int lo, hgh;
    logic prev;
    bit first;
    repeat (dly) @(negedge clk);
    trim_code = code; trim_go = 1'b1;
    @(negedge clk);
    trim_go = 1'b0;
    chk(busy == 1'b1, "R7 busy after trigger", int'(busy), 1);
    prev = reg_clk; first = 1;
    forever begin
      if (first && second) begin trim_code = code2; trim_go = 1'b1; end
      @(negedge clk);
      trim_go = 1'b0; first = 0;
      if (prev && !reg_clk) break;
      prev = reg_clk;
    end
    count_phase(1'b0, lo);
    chk(lo == 64 + expn(code), second ? "R8 ignored retrigger" : (code == 6'h3F ? "R9 zero code" : "R3/R4/R5 corrected low"), lo, 64 + expn(code));
    chk(busy == 1'b1, "R7 busy through corrected high", int'(busy), 1);
    count_phase(1'b1, hgh);
    chk(hgh == 64, "R4 corrected high", hgh, 64);
    chk(busy == 1'b0, "R7 busy clears", int'(busy), 0);
    count_phase(1'b0, lo);
    chk(lo == 64, "R6 next low nominal", lo, 64);
    count_phase(1'b1, hgh);
    chk(hgh == 64, "R6 next high nominal", hgh, 64);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(reg_clk == 1'b0 && busy == 1'b0, "R1 reset state", {reg_clk, busy}, 0);
    rst_n = 1'b1;
    count_phase(1'b0, n);
    chk(n == 64, "R1 first low", n, 64);
    count_phase(1'b1, n);
    chk(n == 64, "R2 nominal high", n, 64);
    count_phase(1'b0, n);
    chk(n == 64, "R2 nominal low", n, 64);
    chk(expn(6'h00) == 1 && expn(6'h1F) == 32 && expn(6'h20) == -31 && expn(6'h3F) == 0, "R3 decode table", expn(6'h20), -31);
    trial(6'h3F, 5, 0, 6'h0);
    trial(6'h1F, 17, 0, 6'h0);
    trial(6'h20, 40, 0, 6'h0);
    trial(6'h00, 0, 0, 6'h0);
    trial(6'h3E, 63, 0, 6'h0);
    trial(6'h20, 3, 1, 6'h1F);
    trial(6'h1F, 90, 1, 6'h20);
    for (int i = 0; i < 30; i++)
      trial(6'($urandom % 64), int'($urandom % 200), ($urandom % 4) == 0, 6'($urandom % 64));
    done = 1;
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntot++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", npass, ntot);
      $finish;
    end
  end
endmodule